// File: doc/BRIEF.md
# Port Function Control Register

This block is one byte of special-function register space that decides what each pin of an 8-bit general-purpose port carries. It holds three things: a CAN pin enable, a sticky flag that records CAN receive activity, and a 3-bit code that hands the upper four port pins to peripheral chip-enable strobes in a fixed fill order. From this state it drives every port pin. A pin drives either the port data latch or the peripheral signal that owns it. The block also reports, for each pin, whether a peripheral owns it.

Software reaches the register through a plain SFR bus: an address, write data, a write strobe and combinational read data. Timed-access protection is applied to the chip-enable code only. A separate sequencer produces a level that marks an open timed-access window, and the code accepts a write only while that level is high. The CAN enable and the activity flag take ordinary writes. The CAN controller, the memory-space decoder that produces the active-low chip-enable strobes, and the timed-access sequencer all sit outside this block.

All the interfaces are control or status pins. None of them carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pcfg_port_ctl`

## Requirements
- R1: After reset, a read at the register address returns 8'h80, no pin is marked as peripheral-owned, every pin output follows the port latch, and `can_rx` is 1.
- R2: A read at the register address returns bit 7 = 1, bit 6 = activity flag, bits 5:4 = 0, bit 3 = CAN enable and bits 2:0 = chip-enable code. A read at any other address returns 8'h00.
- R3: A write to the register address loads bit 3 into the CAN enable, whatever the level of `ta_open`.
- R4: Bits 2:0 of a write are loaded into the chip-enable code only while `ta_open` is 1. When `ta_open` is 0 the code keeps its value, and the other bits of the same write still take effect.
- R5: The activity flag sets on the edge after a cycle in which the CAN enable is 1 and `can_act` is 1. While the CAN enable is 0, `can_act` has no effect on the flag.
- R6: Once set, the activity flag stays set until a register write carries 0 in bit 6. Writing 1 to bit 6 has no effect. If a set and a clearing write fall in the same cycle, the flag ends up set.
- R7: While the CAN enable is 1, pin 0 drives `can_tx`, pin 1 drives 1 (released so it can act as an input), and `can_rx` follows `rx_pad`. Latch bits 0 and 1 have no effect on the pins. While the CAN enable is 0, pins 0 and 1 follow the latch and `can_rx` is 1.
- R8: The chip-enable code assigns pins as follows. 3'b100 gives chip-enable 0 on pin 4. 3'b101 gives pins 5:4. 3'b110 gives pins 6:4. 3'b111 gives pins 7:4, with chip-enable k on pin 4+k. Codes 3'b000 through 3'b011 assign no pin.
- R9: A pin assigned to chip-enable k drives `ce_n[k]` and has its `pin_periph` bit set. Its port latch bit has no effect on it.
- R10: A register write becomes visible on read data and on the pins only after the clock edge that accepts it. Read data is combinational from the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_rdata | output | 8 | SFR read data, 0 when the address does not match |
| ta_open | input | 1 | Timed-access window open |
| can_act | input | 1 | CAN receive activity seen this cycle |
| can_tx | input | 1 | CAN transmit bit from the controller |
| rx_pad | input | 1 | Level on pin 1 |
| can_rx | output | 1 | CAN receive bit to the controller |
| ce_n | input | 4 | Active-low peripheral chip-enable strobes |
| port_latch | input | 8 | Port data register contents |
| pin_out | output | 8 | Pin drive values |
| pin_periph | output | 8 | Per-pin flag: 1 when a peripheral owns the pin |

## Verification
The assertions assume that `sfr_we`, `ta_open` and `can_act` are clean, synchronous levels sampled at the rising edge. They also assume that the chip-enable strobes and `can_tx` are stable away from that edge, so a pin's output can be compared with its source in the same cycle. The stimulus changes every input only on the falling edge and holds write, unlock and activity pulses for exactly one cycle. Same-cycle collisions, such as activity arriving with a clearing write, are set up on purpose.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned BIT_FILL = 7;
  localparam int unsigned BIT_ACT  = 6;
  localparam int unsigned BIT_IOEN = 3;

  typedef struct packed {
    logic              bus_act;
    logic              io_en;
    logic [CODE_W-1:0] ce_code;
  } pcfg_state_t;

  localparam pcfg_state_t PCFG_RESET = '{bus_act: 1'b0, io_en: 1'b0, ce_code: '0};
endpackage

// File: rtl/pcfg_regs.sv
module pcfg_regs
  import pcfg_pkg::*;
#(
  parameter logic [7:0] REG_ADDR = 8'hC6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        sfr_addr,
  input  logic [REG_W-1:0]  sfr_wdata,
  input  logic              sfr_we,
  input  logic              ta_open,
  input  logic              can_act,
  output logic [REG_W-1:0]  sfr_rdata,
  output pcfg_state_t       st
);
  logic hit, wr, act_set, sw_clr;
  pcfg_state_t st_nxt;
  logic unused_wbits;

  assign hit     = (sfr_addr == REG_ADDR);
  assign wr      = hit && sfr_we;
  assign act_set = st.io_en && can_act;
  assign sw_clr  = wr && !sfr_wdata[BIT_ACT];
  assign unused_wbits = ^{sfr_wdata[BIT_FILL], sfr_wdata[5:4]};

  always_comb begin
    st_nxt = st;
    if (wr) begin
      st_nxt.io_en = sfr_wdata[BIT_IOEN];
      if (ta_open) st_nxt.ce_code = sfr_wdata[CODE_W-1:0];
    end
    if (act_set)     st_nxt.bus_act = 1'b1;
    else if (sw_clr) st_nxt.bus_act = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PCFG_RESET;
    else        st <= st_nxt;
  end

  always_comb begin
    sfr_rdata = '0;
    if (hit) begin
      sfr_rdata[BIT_FILL]       = 1'b1;
      sfr_rdata[BIT_ACT]        = st.bus_act;
      sfr_rdata[BIT_IOEN]       = st.io_en;
      sfr_rdata[CODE_W-1:0]     = st.ce_code;
    end
  end

  // R5
  act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.io_en && can_act) |=> st.bus_act);
  // R5
  act_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.io_en && !st.bus_act) |=> !st.bus_act);
  // R6
  act_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.bus_act && !(sfr_we && hit && !sfr_wdata[BIT_ACT])) |=> st.bus_act);
  // R4
  code_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ta_open) |=> $stable(st.ce_code));
  // R3
  ioen_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && hit) |=> (st.io_en == $past(sfr_wdata[BIT_IOEN])));
endmodule

// File: rtl/pcfg_ce_decode.sv
module pcfg_ce_decode
  import pcfg_pkg::*;
#(
  parameter int unsigned NUM_CE = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [NUM_CE-1:0] ce_mask
);
  // Top code bit enables the group; low bits give the highest assigned index.
  logic             grp_on;
  logic [CODE_W-2:0] top_idx;
  assign grp_on  = code[CODE_W-1];
  assign top_idx = code[CODE_W-2:0];

  for (genvar k = 0; k < NUM_CE; k++) begin : g_ce
    if (k < (1 << (CODE_W-1))) begin : g_live
      assign ce_mask[k] = grp_on && ({1'b0, top_idx} >= CODE_W'(k));
    end else begin : g_dead
      assign ce_mask[k] = 1'b0;
    end
  end
endmodule

// File: rtl/pcfg_pin_mux.sv
module pcfg_pin_mux #(
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned NUM_CE  = 4,
  parameter int unsigned CE_BASE = 4
) (
  input  logic              io_en,
  input  logic [NUM_CE-1:0] ce_mask,
  input  logic [NUM_CE-1:0] ce_n,
  input  logic [PORT_W-1:0] port_latch,
  input  logic              can_tx,
  input  logic              rx_pad,
  output logic              can_rx,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_periph
);
  localparam int unsigned TX_PIN = 0;
  localparam int unsigned RX_PIN = 1;

  assign can_rx = io_en ? rx_pad : 1'b1;

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i == TX_PIN) begin : g_tx
      assign pin_out[i]    = io_en ? can_tx : port_latch[i];
      assign pin_periph[i] = io_en;
    end else if (i == RX_PIN) begin : g_rx
      assign pin_out[i]    = io_en ? 1'b1 : port_latch[i];
      assign pin_periph[i] = io_en;
    end else if (i >= CE_BASE && i < CE_BASE + NUM_CE) begin : g_ce
      assign pin_out[i]    = ce_mask[i-CE_BASE] ? ce_n[i-CE_BASE] : port_latch[i];
      assign pin_periph[i] = ce_mask[i-CE_BASE];
    end else begin : g_gpio
      assign pin_out[i]    = port_latch[i];
      assign pin_periph[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pcfg_port_ctl.sv
module pcfg_port_ctl
  import pcfg_pkg::*;
#(
  parameter logic [7:0]  REG_ADDR = 8'hC6,
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned NUM_CE   = 4,
  parameter int unsigned CE_BASE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        sfr_addr,
  input  logic [7:0]        sfr_wdata,
  input  logic              sfr_we,
  output logic [7:0]        sfr_rdata,
  input  logic              ta_open,
  input  logic              can_act,
  input  logic              can_tx,
  input  logic              rx_pad,
  output logic              can_rx,
  input  logic [NUM_CE-1:0] ce_n,
  input  logic [PORT_W-1:0] port_latch,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_periph
);
  pcfg_state_t       st;
  logic [NUM_CE-1:0] ce_mask;

  pcfg_regs #(.REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .ta_open(ta_open), .can_act(can_act),
    .sfr_rdata(sfr_rdata), .st(st)
  );

  pcfg_ce_decode #(.NUM_CE(NUM_CE)) u_dec (
    .code(st.ce_code), .ce_mask(ce_mask)
  );

  pcfg_pin_mux #(.PORT_W(PORT_W), .NUM_CE(NUM_CE), .CE_BASE(CE_BASE)) u_mux (
    .io_en(st.io_en), .ce_mask(ce_mask), .ce_n(ce_n), .port_latch(port_latch),
    .can_tx(can_tx), .rx_pad(rx_pad), .can_rx(can_rx),
    .pin_out(pin_out), .pin_periph(pin_periph)
  );

  // R7
  rx_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.io_en |-> (pin_out[1] && can_rx == rx_pad));
  // R7
  tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.io_en |-> (pin_out[0] == can_tx));
  // R8
  ce_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.ce_code[2]) |-> (pin_periph[PORT_W-1:CE_BASE] == '0));

  for (genvar k = 0; k < NUM_CE; k++) begin : g_chk
    // R9
    ce_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_periph[CE_BASE+k] |-> (pin_out[CE_BASE+k] == ce_n[k]));
    if (k > 0) begin : g_thermo
      // R8
      ce_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_periph[CE_BASE+k] |-> pin_periph[CE_BASE+k-1]);
    end
  end
endmodule

// File: tb/pcfg_port_ctl_tb.sv
module pcfg_port_ctl_tb;
  localparam logic [7:0] ADDR = 8'hC6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = ADDR, sfr_wdata = 8'h00, sfr_rdata;
  logic       sfr_we = 1'b0, ta_open = 1'b0, can_act = 1'b0;
  logic       can_tx = 1'b1, rx_pad = 1'b1, can_rx;
  logic [3:0] ce_n = 4'hF;
  logic [7:0] port_latch = 8'h5A, pin_out, pin_periph;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pcfg_port_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .ta_open(ta_open),
    .can_act(can_act), .can_tx(can_tx), .rx_pad(rx_pad), .can_rx(can_rx),
    .ce_n(ce_n), .port_latch(port_latch), .pin_out(pin_out),
    .pin_periph(pin_periph)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] d, input logic ta);
    @(negedge clk);
    sfr_addr = ADDR; sfr_wdata = d; sfr_we = 1'b1; ta_open = ta;
    @(negedge clk);
    sfr_we = 1'b0; ta_open = 1'b0;
    #1;
  endtask

  task automatic pulse_act();
    @(negedge clk); can_act = 1'b1;
    @(negedge clk); can_act = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(sfr_rdata, 8'h80, "R1 reset read");
    chk(pin_periph, 8'h00, "R1 reset ownership");
    chk(pin_out, port_latch, "R1 reset pins");
    chk({7'd0, can_rx}, 8'h01, "R1 reset can_rx");
    sfr_addr = 8'hC7; #1;
    chk(sfr_rdata, 8'h00, "R2 other address");
    sfr_addr = ADDR; #1;
  endtask

  task automatic t_timed_field();
    reg_write(8'h07, 1'b0);
    chk(sfr_rdata, 8'h80, "R4 code locked");
    reg_write(8'h0F, 1'b0);
    chk(sfr_rdata, 8'h88, "R3 R4 enable loads, code locked");
    reg_write(8'hB6, 1'b1);
    chk(sfr_rdata, 8'h86, "R2 R3 R4 unlocked code, reserved bits");
    reg_write(8'h00, 1'b1);
    chk(sfr_rdata, 8'h80, "R3 R4 cleared");
  endtask

  task automatic t_decode();
    port_latch = 8'hFF; ce_n = 4'h0;
    for (int c = 0; c < 8; c++) begin
      logic [3:0] m;
      m = (c >= 4) ? 4'((1 << (c - 3)) - 1) : 4'h0;
      reg_write(8'(c), 1'b1);
      chk(sfr_rdata, 8'h80 | 8'(c), "R8 code readback");
      chk(pin_periph, {m, 4'h0}, "R8 ownership");
      chk(pin_out, {~m, 4'hF}, "R9 owned pins follow strobe");
    end
  endtask

  task automatic t_latch_blocked();
    reg_write(8'h07, 1'b1);
    ce_n = 4'hA; port_latch = 8'h00; #1;
    chk(pin_out, 8'hA0, "R9 latch low ignored");
    port_latch = 8'hFF; #1;
    chk(pin_out, 8'hAF, "R9 latch high ignored");
    reg_write(8'h05, 1'b1);
    port_latch = 8'h00; ce_n = 4'h0; #1;
    chk(pin_out, 8'h00, "R8 partial strobes");
    ce_n = 4'hF; #1;
    chk(pin_out, 8'h30, "R8 R9 code 101 pins 5:4");
    reg_write(8'h00, 1'b1);
  endtask

  task automatic t_can_mux();
    port_latch = 8'hFF; can_tx = 1'b0; rx_pad = 1'b0;
    @(negedge clk);
    sfr_wdata = 8'h08; sfr_we = 1'b1; #1;
    chk(sfr_rdata, 8'h80, "R10 write not yet visible");
    chk(pin_out, 8'hFF, "R10 pins before edge");
    @(negedge clk); sfr_we = 1'b0; #1;
    chk(sfr_rdata, 8'h88, "R10 write visible after edge");
    chk(pin_out, 8'hFE, "R7 pin0 drives can_tx");
    chk({7'd0, can_rx}, 8'h00, "R7 can_rx follows pad");
    chk(pin_periph, 8'h03, "R7 pins 1:0 owned");
    port_latch = 8'h00; can_tx = 1'b1; #1;
    chk(pin_out, 8'h03, "R7 latch bits 1:0 ignored");
    reg_write(8'h00, 1'b0);
    chk(pin_out, 8'h00, "R7 pins back to latch");
    chk({7'd0, can_rx}, 8'h01, "R7 can_rx idle when disabled");
    rx_pad = 1'b1;
  endtask

  task automatic t_flag();
    pulse_act();
    chk(sfr_rdata, 8'h80, "R5 activity ignored while disabled");
    reg_write(8'h08, 1'b0);
    pulse_act();
    chk(sfr_rdata, 8'hC8, "R5 flag sets");
    reg_write(8'h48, 1'b0);
    chk(sfr_rdata, 8'hC8, "R6 write 1 keeps flag");
    repeat (3) @(negedge clk);
    #1;
    chk(sfr_rdata, 8'hC8, "R6 flag sticky");
    reg_write(8'h08, 1'b0);
    chk(sfr_rdata, 8'h88, "R6 write 0 clears");
    @(negedge clk);
    sfr_wdata = 8'h08; sfr_we = 1'b1; can_act = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0; can_act = 1'b0; #1;
    chk(sfr_rdata, 8'hC8, "R6 set wins over clear");
    reg_write(8'h00, 1'b0);
    chk(sfr_rdata, 8'h80, "R6 cleared with enable off");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timed_field();
    t_decode();
    t_latch_blocked();
    t_can_mux();
    t_flag();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule